// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers interrupt requests from up to fifteen on-chip sources and turns them into one interrupt level for the processor. A request pulse on a source sets a sticky pending bit. Software reads the pending bits, chooses which sources may interrupt through a disable mask, and drops pending bits by writing ones to a clear register. A separate force register lets test software raise any level with no peripheral activity at all. The two serial-channel character events arrive on sources 4 and 5. The other sources come from timers and other internal logic.

The output level is the number of the highest unmasked source that is pending or forced. A value of zero means no interrupt. When the processor takes an interrupt, it returns the level on the acknowledge inputs, and that source's pending and force bits drop.

Registers sit on a plain single-cycle bus with a write strobe, a byte address, write data and read data. The read data is combinational from the addressed register.

Top module: `irqc_top`

## Requirements
- R1: After reset, pending reads 0x0000, force reads 0x0000, mask reads 0xFFFE (every source disabled) and the level output is 0.
- R2: Offset 0x48 reads pending, and writes to it are ignored. Offset 0x4C reads and writes the mask. Offset 0x50 takes clear writes and reads 0. Offset 0x54 reads and writes force. Any other offset reads 0, and a write there changes no register.
- R3: Bit n of every register stands for level n. Bit 0 always reads 0, and a request on source 0 is ignored.
- R4: A request held high on `irq_req[n]` for one clock sets pending bit n at that edge. The bit stays set after the request drops.
- R5: A write to offset 0x50 clears every pending bit whose data bit is 1 and leaves the other pending bits alone.
- R6: A request on source n in the same clock as a clear write or an acknowledge of n wins, so pending bit n is 1 after that edge.
- R7: A mask bit of 1 keeps its source out of the level output. The pending bit is still latched while masked.
- R8: A force bit of 1 makes its level active without any request. Force bits read back at 0x54 and do not show in the pending register.
- R9: `irq_level` equals the highest n for which (pending[n] or force[n]) and not mask[n] holds. It is 0 when no such n exists.
- R10: An acknowledge with level n (n from 1 to 15) clears pending bit n and force bit n at that edge. If a force register write happens in the same clock, the written force value wins.
- R11: Register updates take effect at the clock edge that samples them. `irq_level` shows the new state right after that edge, and read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_req | input | 16 | Request per source; bit 0 unused |
| irq_ack | input | 1 | Processor takes an interrupt |
| irq_ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest active unmasked level, 0 if none |

## Verification
Every register has a latency of one edge. A write, clear, request or acknowledge that is sampled at an edge shows on `irq_level` and on the read data as soon as that edge has passed. Read data needs no extra cycle, because it follows the address combinationally. The bench drives inputs at the falling edge, moves its behavioural model at the rising edge, and compares level and read data a quarter period after each falling edge. At that point both the inputs and the state are settled. Directed reads and one explicit check before the edge and one after it pin down the cycle in which the level changes.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt controller: register offsets and
// the fixed size of the level space. Assumes byte offsets on an 8-bit bus.
package irqc_pkg;
    localparam int IRQC_LVLS     = 16;
    localparam logic [7:0] OFS_PEND  = 8'h48;
    localparam logic [7:0] OFS_MASK  = 8'h4C;
    localparam logic [7:0] OFS_CLEAR = 8'h50;
    localparam logic [7:0] OFS_FORCE = 8'h54;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_MASK,
        SEL_CLEAR,
        SEL_FORCE
    } reg_sel_e;
endpackage

// File: rtl/irqc_decode.sv
// Address decoder: maps a byte offset onto one register select and
// qualifies the write strobes. Assumes the offset is compared in full.
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    output reg_sel_e          sel,
    output logic              we_mask,
    output logic              we_clear,
    output logic              we_force
);
    // Choose the addressed register; unknown offsets select none.
    always_comb begin
        unique case (reg_addr)
            ADDR_W'(OFS_PEND):  sel = SEL_PEND;
            ADDR_W'(OFS_MASK):  sel = SEL_MASK;
            ADDR_W'(OFS_CLEAR): sel = SEL_CLEAR;
            ADDR_W'(OFS_FORCE): sel = SEL_FORCE;
            default:            sel = SEL_NONE;
        endcase
    end

    // Qualify write strobes; the pending register has none.
    always_comb begin
        we_mask  = reg_wr && (sel == SEL_MASK);
        we_clear = reg_wr && (sel == SEL_CLEAR);
        we_force = reg_wr && (sel == SEL_FORCE);
    end
endmodule

// File: rtl/irqc_state.sv
// Per-level state: sticky pending, disable mask and test force bits.
// One slice per level from 1 upward; level 0 is tied to zero.
// Assumes at most one acknowledge per cycle. A request beats a clear
// or an acknowledge, and a force write beats an acknowledge.
module irqc_state #(
    parameter int NUM_LVL = 16,
    parameter int LVL_W   = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] req,
    input  logic [NUM_LVL-1:0] wdata,
    input  logic               we_mask,
    input  logic               we_clear,
    input  logic               we_force,
    input  logic               ack,
    input  logic [LVL_W-1:0]   ack_level,
    output logic [NUM_LVL-1:0] pend_q,
    output logic [NUM_LVL-1:0] mask_q,
    output logic [NUM_LVL-1:0] frc_q
);
    assign pend_q[0] = 1'b0;
    assign mask_q[0] = 1'b0;
    assign frc_q[0]  = 1'b0;

    for (genvar i = 1; i < NUM_LVL; i++) begin : g_lvl
        logic ack_hit;
        assign ack_hit = ack && (ack_level == LVL_W'(i));

        // Pending bit: set by request, dropped by clear or acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)                          pend_q[i] <= 1'b0;
            else if (req[i])                     pend_q[i] <= 1'b1;
            else if ((we_clear && wdata[i]) || ack_hit) pend_q[i] <= 1'b0;
        end

        // Mask bit: disabled at reset, loaded by software.
        always_ff @(posedge clk) begin
            if (!rst_n)       mask_q[i] <= 1'b1;
            else if (we_mask) mask_q[i] <= wdata[i];
        end

        // Force bit: loaded by software, dropped by acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)        frc_q[i] <= 1'b0;
            else if (we_force) frc_q[i] <= wdata[i];
            else if (ack_hit)  frc_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqc_prio.sv
// Fixed-priority encoder: returns the index of the highest set bit of
// the active vector, or zero when none is set. Bit 0 is never reported.
module irqc_prio #(
    parameter int NUM_LVL = 16,
    parameter int LVL_W   = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] active,
    output logic [LVL_W-1:0]   level
);
    // Scan upward so the highest set index is the one kept.
    always_comb begin
        level = '0;
        for (int i = 1; i < NUM_LVL; i++) begin
            if (active[i]) level = LVL_W'(i);
        end
    end
endmodule

// File: rtl/irqc_top.sv
// Interrupt controller top: decoder, per-level state, priority encoder
// and the read multiplexer. Assumes DATA_W >= NUM_LVL and one-cycle bus
// accesses with combinational read data.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int NUM_LVL = IRQC_LVLS,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_LVL-1:0] irq_req,
    input  logic               irq_ack,
    input  logic [LVL_W-1:0]   irq_ack_level,
    output logic [LVL_W-1:0]   irq_level
);
    reg_sel_e           sel;
    logic               we_mask, we_clear, we_force;
    logic [NUM_LVL-1:0] pend_q, mask_q, frc_q;
    logic [NUM_LVL-1:0] active;
    logic [NUM_LVL-1:0] rd_val;
    logic               unused_bits;

    assign unused_bits = ^{reg_wdata[DATA_W-1:NUM_LVL], irq_req[0]};

    irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .sel      (sel),
        .we_mask  (we_mask),
        .we_clear (we_clear),
        .we_force (we_force)
    );

    irqc_state #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (irq_req),
        .wdata     (reg_wdata[NUM_LVL-1:0]),
        .we_mask   (we_mask),
        .we_clear  (we_clear),
        .we_force  (we_force),
        .ack       (irq_ack),
        .ack_level (irq_ack_level),
        .pend_q    (pend_q),
        .mask_q    (mask_q),
        .frc_q     (frc_q)
    );

    // Sources that may interrupt now: pending or forced, and enabled.
    assign active = (pend_q | frc_q) & ~mask_q;

    irqc_prio #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_prio (
        .active (active),
        .level  (irq_level)
    );

    // Read multiplexer; clear and unknown offsets read zero.
    always_comb begin
        unique case (sel)
            SEL_PEND:  rd_val = pend_q;
            SEL_MASK:  rd_val = mask_q;
            SEL_FORCE: rd_val = frc_q;
            default:   rd_val = '0;
        endcase
        reg_rdata = DATA_W'(rd_val);
    end
endmodule

// File: rtl/irqc_checker.sv
// Property checker for irqc_top, attached with bind. Observes ports and
// the state registers; holds no state of its own.
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_LVL = 16,
    parameter int LVL_W   = $clog2(NUM_LVL)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_LVL-1:0] wdata,
    input logic [NUM_LVL-1:0] irq_req,
    input logic               irq_ack,
    input logic [LVL_W-1:0]   irq_ack_level,
    input logic [LVL_W-1:0]   irq_level,
    input logic [NUM_LVL-1:0] pend,
    input logic [NUM_LVL-1:0] mask,
    input logic [NUM_LVL-1:0] frc
);
    localparam logic [NUM_LVL-1:0] LIVE = {{(NUM_LVL-1){1'b1}}, 1'b0};

    logic [NUM_LVL-1:0] act;
    logic               clr_wr, frc_wr;
    assign act    = (pend | frc) & ~mask;
    assign clr_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CLEAR));
    assign frc_wr = reg_wr && (reg_addr == ADDR_W'(OFS_FORCE));

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend == '0 && frc == '0 && mask == LIVE && irq_level == '0));

    assert_bit0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] == 1'b0 && mask[0] == 1'b0 && frc[0] == 1'b0));

    assert_req_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & LIVE) != '0) |=> ((pend & $past(irq_req & LIVE)) == $past(irq_req & LIVE)));

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((pend & $past(wdata & ~irq_req)) == '0));

    assert_req_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && ((wdata & irq_req & LIVE) != '0)) |=> ((pend & $past(wdata & irq_req & LIVE)) != '0));

    assert_masked_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> !mask[irq_level]);

    assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> (irq_level == '0));

    assert_top_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (act[irq_level] && ((act >> irq_level) == NUM_LVL'(1))));

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_ack_level != '0 && !irq_req[irq_ack_level] && !frc_wr)
        |=> (!pend[$past(irq_ack_level)] && !frc[$past(irq_ack_level)]));
endmodule

bind irqc_top irqc_checker #(
    .ADDR_W  (ADDR_W),
    .NUM_LVL (NUM_LVL),
    .LVL_W   (LVL_W)
) u_irqc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .wdata         (reg_wdata[NUM_LVL-1:0]),
    .irq_req       (irq_req),
    .irq_ack       (irq_ack),
    .irq_ack_level (irq_ack_level),
    .irq_level     (irq_level),
    .pend          (pend_q),
    .mask          (mask_q),
    .frc           (frc_q)
);

// File: tb/tb_irqc_top.sv
// Bench for irqc_top: behavioural model updated at each rising edge,
// compared on every cycle, plus directed checks per requirement.
module tb_irqc_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] irq_req = '0;
    logic        irq_ack = 1'b0;
    logic [3:0]  irq_ack_level = '0;
    logic [3:0]  irq_level;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    logic [15:0] m_pend = '0, m_mask = 16'hFFFE, m_frc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_req (irq_req),
        .irq_ack (irq_ack), .irq_ack_level (irq_ack_level), .irq_level (irq_level)
    );

    // Model: one behavioural step per rising edge.
    always @(posedge clk) begin
        logic [15:0] np, nm, nf;
        if (!rst_n) begin
            np = '0; nm = 16'hFFFE; nf = '0;
        end else begin
            np = m_pend; nm = m_mask; nf = m_frc;
            if (reg_wr && reg_addr == 8'h4C) nm = reg_wdata[15:0] & 16'hFFFE;
            if (reg_wr && reg_addr == 8'h50) np = np & ~reg_wdata[15:0];
            if (irq_ack && irq_ack_level != 0) begin
                np[irq_ack_level] = 1'b0;
                nf[irq_ack_level] = 1'b0;
            end
            if (reg_wr && reg_addr == 8'h54) nf = reg_wdata[15:0] & 16'hFFFE;
            np = np | (irq_req & 16'hFFFE);
        end
        m_pend <= np; m_mask <= nm; m_frc <= nf;
    end

    function automatic logic [3:0] model_level();
        for (int b = 15; b >= 1; b--)
            if ((m_pend[b] || m_frc[b]) && !m_mask[b]) return 4'(b);
        return 4'd0;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h48:   return {16'h0, m_pend};
            8'h4C:   return {16'h0, m_mask};
            8'h54:   return {16'h0, m_frc};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison, a quarter period after the falling edge.
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (cmp_en) begin
            check("R9 level vs model", {28'h0, irq_level}, {28'h0, model_level()});
            check("R2 rdata vs model", reg_rdata, model_read(reg_addr));
        end
    end

    // One clock of stimulus, driven at the falling edge and removed after the rise.
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [15:0] req, input logic ack, input logic [3:0] al);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; irq_req = req;
        irq_ack = ack; irq_ack_level = al;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; reg_wdata = '0; irq_req = '0; irq_ack = 1'b0; irq_ack_level = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 16'h0, 1'b0, 4'd0);
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #2;
        check(tag, reg_rdata, exp);
    endtask

    task automatic lvl(input string tag, input logic [3:0] exp);
        @(negedge clk);
        #2;
        check(tag, {28'h0, irq_level}, {28'h0, exp});
    endtask

    task automatic run_tests();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R1 reset values
        rd("R1 pending after reset", 8'h48, 32'h0);
        rd("R1 mask after reset", 8'h4C, 32'h0000_FFFE);
        rd("R1 force after reset", 8'h54, 32'h0);
        lvl("R1 level after reset", 4'd0);
        // R3 bit 0 unused
        step(1'b0, 8'h00, 32'h0, 16'h0001, 1'b0, 4'd0);
        rd("R3 source 0 ignored", 8'h48, 32'h0);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd("R3 mask bit0 reads 0", 8'h4C, 32'h0000_FFFE);
        // R4 serial channel events on 4 and 5, R7 latched while masked
        step(1'b0, 8'h00, 32'h0, 16'h0030, 1'b0, 4'd0);
        repeat (2) @(posedge clk);
        rd("R4 pending sticky", 8'h48, 32'h0000_0030);
        lvl("R7 masked sources silent", 4'd0);
        wr(8'h4C, 32'h0);
        lvl("R9 highest of 4,5", 4'd5);
        // R5 clear
        wr(8'h50, 32'h0000_0020);
        rd("R5 clear bit 5 only", 8'h48, 32'h0000_0010);
        rd("R2 clear reads zero", 8'h50, 32'h0);
        lvl("R5 level after clear", 4'd4);
        // R6 request beats clear
        step(1'b1, 8'h50, 32'h0000_0010, 16'h0010, 1'b0, 4'd0);
        rd("R6 request wins over clear", 8'h48, 32'h0000_0010);
        // R8 force
        wr(8'h54, 32'h0000_8000);
        lvl("R8 forced level 15", 4'd15);
        rd("R8 force readback", 8'h54, 32'h0000_8000);
        rd("R8 pending unaffected", 8'h48, 32'h0000_0010);
        // R2 ignored writes
        wr(8'h48, 32'hFFFF_FFFF);
        rd("R2 pending write ignored", 8'h48, 32'h0000_0010);
        wr(8'h40, 32'hFFFF_FFFF);
        rd("R2 unmapped reads zero", 8'h40, 32'h0);
        rd("R2 mask untouched", 8'h4C, 32'h0);
        rd("R2 force untouched", 8'h54, 32'h0000_8000);
        // R7 and R9 mask the top level
        wr(8'h4C, 32'h0000_8000);
        lvl("R7 masked 15 falls to 4", 4'd4);
        // R10 acknowledge
        step(1'b0, 8'h00, 32'h0, 16'h0, 1'b1, 4'd4);
        rd("R10 ack clears pending", 8'h48, 32'h0);
        lvl("R10 level after ack", 4'd0);
        wr(8'h4C, 32'h0);
        wr(8'h54, 32'h0000_0006);
        lvl("R9 forced 1,2 gives 2", 4'd2);
        step(1'b0, 8'h00, 32'h0, 16'h0, 1'b1, 4'd2);
        rd("R10 ack clears force", 8'h54, 32'h0000_0002);
        // R6 request beats ack, R10 force still cleared
        step(1'b0, 8'h00, 32'h0, 16'h0002, 1'b1, 4'd1);
        rd("R6 request wins over ack", 8'h48, 32'h0000_0002);
        rd("R10 force 1 cleared", 8'h54, 32'h0);
        // R10 force write wins over ack
        step(1'b1, 8'h54, 32'h0000_0100, 16'h0, 1'b1, 4'd8);
        rd("R10 force write beats ack", 8'h54, 32'h0000_0100);
        // R11 timing of the level change
        @(negedge clk);
        irq_req = 16'h0200;
        #2;
        check("R11 level before edge", {28'h0, irq_level}, 32'd8);
        @(posedge clk);
        #1;
        irq_req = '0;
        check("R11 level right after edge", {28'h0, irq_level}, 32'd9);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (WATCHDOG) @(posedge clk);
                errors++;
                $display("FAIL R11 watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule